// File: doc/BRIEF.md
# Serial Sampling Converter Control and Power Sequencer

This block is the digital half of an eight-channel, 12-bit serial sampling converter. A host frames each transfer with an active-low select line and toggles a serial clock. The block takes an 8-bit control word in at the start of the frame. It returns a 16-bit answer made of four zero bits followed by the 12-bit sample, most significant bit first. A digital stand-in replaces the analog front end. The host supplies one 12-bit value per channel on a flat bus, and the block latches the value of the selected channel at the sampling point of the frame.

The block also sequences the converter's power state. In normal mode it stays powered. Full shutdown powers it down and keeps the control settings. Autoshutdown wakes the converter at the first serial-clock fall of a frame and powers it down again at the end of the frame. A wake-up window counted in system clocks decides whether a sample was taken on a fully powered converter. Every serial input is synchronised to the system clock, and all behaviour is driven by detected edges.

Top module: `sadc_serial_ctrl`

## Requirements
- R1: After reset, dout is 0 and powered is 1. The control setting is channel 0 in normal mode, so the first complete frame returns channel 0.
- R2: din is taken on the first eight serial-clock rises of a frame, first bit as word bit 7. Word bits [5:3] give the channel and bits [1:0] give the power mode; bits 7, 6 and 2 are ignored. The new word takes effect at the eighth rise, so it selects the channel for the next frame's sample.
- R3: dout is 0 while select is high and right after select falls. After serial-clock fall k (k=1..16), dout holds bit 16-k of {4'b0000, result}, where result is the selected channel's value taken at the second rise.
- R4: samp_strobe pulses for one cycle at the second rise of each frame. samp_ok pulses with it exactly when the converter is powered at that point.
- R5: conv_done pulses once at the sixteenth rise of a frame.
- R6: With mode 00 (normal), powered stays high, and it is 1 at the end of every frame.
- R7: With mode 01 (full shutdown), or 11 which acts the same, powered drops at the sixteenth rise and frames do not wake the converter. The stored channel is kept.
- R8: Writing mode 00 while powered down raises powered at the sixteenth rise of that frame.
- R9: In mode 10 (autoshutdown) with the converter down, the first fall of a frame starts a wake count of WAKE_US*CLKS_PER_US system clocks. powered rises when the count ends and drops again at the sixteenth rise.
- R10: A sample taken before the wake count has ended gives samp_ok low, but the result is still returned on dout.
- R11: If select rises before the sixteenth rise, the frame is dropped: no conv_done and no power change. The control setting changes only if at least eight rises were seen.
- R12: Moving from full shutdown to autoshutdown leaves powered low at the end of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial control data |
| ain_flat | input | 96 | Eight 12-bit channel values, channel i at bits [12i+11:12i] |
| dout | output | 1 | Serial result data |
| powered | output | 1 | Converter is fully powered |
| samp_strobe | output | 1 | One-cycle pulse at the sampling point |
| samp_ok | output | 1 | Sample was taken while powered |
| conv_done | output | 1 | One-cycle pulse at frame completion |

## Verification
A change on a serial input passes through two synchroniser flops and an edge-detect flop, and then one registered pulse. Outputs therefore respond four system clocks after the input change. The bench holds each serial-clock phase for eight clocks and reads dout and powered at a falling system-clock edge at the end of that phase, well after the change has settled. The single-cycle pulses are counted by a monitor on every falling clock edge, and the counts are compared once per frame. The wake window is 500 clocks, and the bench's long-gap frames place the sampling point 700 clocks after the first fall.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  localparam int CHAN_W = 3;

  typedef enum logic [1:0] {
    PM_NORMAL   = 2'b00,
    PM_FULL_OFF = 2'b01,
    PM_AUTO_OFF = 2'b10,
    PM_OFF_ALT  = 2'b11
  } pmode_e;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    pmode_e            pm;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{chan: '0, pm: PM_NORMAL};
endpackage

// File: rtl/sadc_sync_edge.sv
module sadc_sync_edge #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in_raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0][STAGES:0] sr;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) sr[i] <= {(STAGES+1){RST_VAL[i]}};
      else     sr[i] <= {sr[i][STAGES-1:0], in_raw[i]};
    end
    assign lvl[i]  = sr[i][STAGES-1];
    assign rise[i] = sr[i][STAGES-1] & ~sr[i][STAGES];
    assign fall[i] = ~sr[i][STAGES-1] & sr[i][STAGES];
  end
endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
  import adcif_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CTL_BITS = 8,
  parameter int SAMPLE_EDGE = 2,
  parameter int CH_LSB = 3,
  parameter int PM_LSB = 0,
  localparam int CW = $clog2(FRAME_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_lvl,
  input  logic          cs_fall,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          din_lvl,
  output ctl_t          ctl,
  output logic          in_frame,
  output logic          samp_pulse,
  output logic          end_pulse,
  output logic          first_fall,
  output logic          fall_pulse,
  output logic [CW-1:0] fall_num
);
  localparam logic [CW-1:0] FULL_CNT = CW'(FRAME_BITS);
  localparam logic [CW-1:0] LAST_R   = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] CTL_CNT  = CW'(CTL_BITS);
  localparam logic [CW-1:0] CTL_LAST = CW'(CTL_BITS - 1);
  localparam logic [CW-1:0] SMP_R    = CW'(SAMPLE_EDGE - 1);

  logic [CW-1:0]       rcnt, fcnt;
  logic [CTL_BITS-1:0] shreg, word_nxt;

  assign word_nxt = {shreg[CTL_BITS-2:0], din_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame   <= 1'b0;
      rcnt       <= '0;
      fcnt       <= '0;
      shreg      <= '0;
      ctl        <= CTL_RESET;
      samp_pulse <= 1'b0;
      end_pulse  <= 1'b0;
      first_fall <= 1'b0;
      fall_pulse <= 1'b0;
      fall_num   <= '0;
    end else begin
      samp_pulse <= 1'b0;
      end_pulse  <= 1'b0;
      first_fall <= 1'b0;
      fall_pulse <= 1'b0;
      if (cs_fall) begin
        in_frame <= 1'b1;
        rcnt     <= '0;
        fcnt     <= '0;
      end else if (cs_lvl) begin
        in_frame <= 1'b0;
      end else if (in_frame) begin
        if (sck_rise && rcnt < FULL_CNT) begin
          rcnt <= rcnt + 1'b1;
          if (rcnt < CTL_CNT) shreg <= word_nxt;
          if (rcnt == CTL_LAST)
            ctl <= '{chan: word_nxt[CH_LSB +: CHAN_W], pm: pmode_e'(word_nxt[PM_LSB +: 2])};
          samp_pulse <= (rcnt == SMP_R);
          end_pulse  <= (rcnt == LAST_R);
        end
        if (sck_fall && fcnt < FULL_CNT) begin
          fcnt       <= fcnt + 1'b1;
          first_fall <= (fcnt == '0);
          fall_pulse <= 1'b1;
          fall_num   <= fcnt + 1'b1;
        end
      end
    end
  end

  AST_CTL_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_frame |=> $stable(ctl)); // R11
  AST_ONE_END_PULSE: assert property (@(posedge clk) disable iff (rst)
    end_pulse |=> !end_pulse); // R5
  AST_RCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    rcnt <= FULL_CNT); // R5
endmodule

// File: rtl/sadc_power_seq.sv
module sadc_power_seq
  import adcif_pkg::*;
#(
  parameter int WAKE_CLKS = 500,
  localparam int WW = $clog2(WAKE_CLKS + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  pmode_e pm,
  input  logic   first_fall,
  input  logic   end_pulse,
  output logic   powered,
  output logic   waking
);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CLKS - 1);
  logic [WW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      powered <= 1'b1;
      waking  <= 1'b0;
      wcnt    <= '0;
    end else if (end_pulse) begin
      powered <= (pm == PM_NORMAL);
      waking  <= 1'b0;
    end else if (first_fall && pm == PM_AUTO_OFF && !powered && !waking) begin
      waking <= 1'b1;
      wcnt   <= '0;
    end else if (waking) begin
      if (wcnt == WAKE_LAST) begin
        powered <= 1'b1;
        waking  <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  AST_NORMAL_STAYS_UP: assert property (@(posedge clk) disable iff (rst)
    (pm == PM_NORMAL && powered) |=> powered); // R6
  AST_WAKE_WHILE_DOWN: assert property (@(posedge clk) disable iff (rst)
    waking |-> !powered); // R9
  AST_FULL_OFF_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    (pm == PM_FULL_OFF && !powered && !waking) |=> !powered); // R7
endmodule

// File: rtl/sadc_serial_ctrl.sv
module sadc_serial_ctrl
  import adcif_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RES_W = 12,
  parameter int FRAME_BITS = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CLKS_PER_US = 100,
  parameter int WAKE_US = 5,
  localparam int CW = $clog2(FRAME_BITS + 1),
  localparam int IW = $clog2(FRAME_BITS),
  localparam int LEAD = FRAME_BITS - RES_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               din,
  input  logic [NCH*RES_W-1:0] ain_flat,
  output logic               dout,
  output logic               powered,
  output logic               samp_strobe,
  output logic               samp_ok,
  output logic               conv_done
);
  logic [2:0] s_lvl, s_rise, s_fall;
  ctl_t          ctl;
  logic          in_frame, samp_pulse, end_pulse, first_fall, fall_pulse, waking;
  logic [CW-1:0] fall_num;
  logic [RES_W-1:0]      res;
  logic [FRAME_BITS-1:0] word;
  logic [IW-1:0]         idx;

  sadc_sync_edge #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst(rst), .in_raw({din, sclk, cs_n}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  sadc_frame_seq #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk(clk), .rst(rst), .cs_lvl(s_lvl[0]), .cs_fall(s_fall[0]),
    .sck_rise(s_rise[1]), .sck_fall(s_fall[1]), .din_lvl(s_lvl[2]),
    .ctl(ctl), .in_frame(in_frame), .samp_pulse(samp_pulse), .end_pulse(end_pulse),
    .first_fall(first_fall), .fall_pulse(fall_pulse), .fall_num(fall_num)
  );

  sadc_power_seq #(.WAKE_CLKS(CLKS_PER_US * WAKE_US)) u_pwr (
    .clk(clk), .rst(rst), .pm(ctl.pm), .first_fall(first_fall),
    .end_pulse(end_pulse), .powered(powered), .waking(waking)
  );

  assign word = {{LEAD{1'b0}}, res};
  assign idx  = IW'(FRAME_BITS - int'(fall_num));

  always_ff @(posedge clk) begin
    if (rst) begin
      res         <= '0;
      dout        <= 1'b0;
      samp_strobe <= 1'b0;
      samp_ok     <= 1'b0;
      conv_done   <= 1'b0;
    end else begin
      samp_strobe <= samp_pulse;
      samp_ok     <= samp_pulse && powered;
      conv_done   <= end_pulse;
      if (samp_pulse) res <= ain_flat[int'(ctl.chan)*RES_W +: RES_W];
      if (s_lvl[0] || s_fall[0]) dout <= 1'b0;
      else if (fall_pulse)       dout <= word[idx];
    end
  end

  AST_LEAD_ZEROS: assert property (@(posedge clk) disable iff (rst)
    (fall_pulse && int'(fall_num) <= LEAD) |=> !dout); // R3
  AST_IDLE_DOUT_LOW: assert property (@(posedge clk) disable iff (rst)
    (!in_frame && s_lvl[0]) |=> !dout); // R3
endmodule

// File: tb/sadc_serial_ctrl_test.sv
`timescale 1ns/1ps
module sadc_serial_ctrl_test;
  localparam int H = 8;
  localparam int WAKE = 500;
  logic clk = 0, rst = 1, cs_n = 1, sclk = 1, din = 0;
  logic [95:0] ain_flat = '0;
  logic dout, powered, samp_strobe, samp_ok, conv_done;
  int errors = 0, checks = 0;
  int n_samp = 0, n_ok = 0, n_done = 0;
  int mch = 0, mpm = 0, frame_no = 0;
  bit mpow = 1;
  logic start_dout, mid_pow;
  logic [15:0] got;

  always #5 clk = ~clk;

  sadc_serial_ctrl uut (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .ain_flat(ain_flat), .dout(dout), .powered(powered), .samp_strobe(samp_strobe),
    .samp_ok(samp_ok), .conv_done(conv_done));

  always @(negedge clk) if (!rst) begin
    if (samp_strobe) n_samp++;
    if (samp_ok) n_ok++;
    if (conv_done) n_done++;
  end

  task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] chval(input int i, input int p);
    return 12'((i * 419 + p * 1237 + 92) & 12'hFFF);
  endfunction

  task automatic frame(input logic [7:0] w, input int nrise, input int gap, input string ptag);
    int s0, k0, d0, exp_ok;
    logic [15:0] exp_word;
    bit auto_down;
    for (int i = 0; i < 8; i++) ain_flat[i*12 +: 12] = chval(i, frame_no);
    frame_no++;
    exp_word = {4'b0000, ain_flat[mch*12 +: 12]};
    auto_down = (mpm == 2) && !mpow;
    exp_ok = (mpow || (auto_down && gap >= WAKE + 100)) ? 1 : 0;
    s0 = n_samp; k0 = n_ok; d0 = n_done;
    got = '0;
    @(negedge clk); cs_n = 0;
    repeat (H) @(negedge clk);
    start_dout = dout;
    for (int k = 1; k <= 16; k++) begin
      sclk = 0; din = (k <= 8) ? w[8-k] : 1'b0;
      if (k == 1) begin
        repeat (gap) @(negedge clk);
        mid_pow = powered;
      end
      repeat (H) @(negedge clk);
      got[16-k] = dout;
      if (k > nrise) break;
      sclk = 1;
      repeat (H) @(negedge clk);
    end
    cs_n = 1;
    repeat (H) @(negedge clk);
    sclk = 1;
    repeat (H) @(negedge clk);
    chk(start_dout == 1'b0, "R3", "dout after select fall", int'(start_dout), 0);
    if (nrise >= 2) begin
      chk(n_samp - s0 == 1, "R4", "samp_strobe count", n_samp - s0, 1);
      chk(n_ok - k0 == exp_ok, exp_ok ? "R4" : "R10", "samp_ok count", n_ok - k0, exp_ok);
    end
    if (auto_down)
      chk(mid_pow == (gap >= WAKE + 100), "R9", "powered after wake gap", int'(mid_pow), int'(gap >= WAKE + 100));
    if (nrise == 16) begin
      chk(got == exp_word, "R3", "result word", int'(got), int'(exp_word));
      chk(n_done - d0 == 1, "R5", "conv_done count", n_done - d0, 1);
    end else begin
      chk(n_done - d0 == 0, "R11", "conv_done on abort", n_done - d0, 0);
    end
    if (nrise >= 8) begin mch = int'(w[5:3]); mpm = int'(w[1:0]); end
    if (nrise == 16) mpow = (mpm == 0);
    chk(powered == mpow, ptag, "powered after frame", int'(powered), int'(mpow));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    chk(dout == 1'b0, "R1", "dout at reset", int'(dout), 0);
    chk(powered == 1'b1, "R1", "powered at reset", int'(powered), 1);
    // R1/R2: channel sweep in normal mode, don't-care bits varied
    for (int i = 0; i < 9; i++) begin
      logic [2:0] ch = 3'((7 - i) & 7);
      frame({2'(i), ch, 1'(i), 2'b00}, 16, 0, i == 0 ? "R1" : "R6");
    end
    frame({2'b11, 3'd3, 1'b1, 2'b01}, 16, 0, "R7");   // R7 enter full shutdown
    frame({2'b00, 3'd5, 1'b0, 2'b01}, 16, 0, "R7");   // R7 stays down, channel kept
    frame({2'b00, 3'd5, 1'b0, 2'b00}, 16, 0, "R8");   // R8 power up at end
    frame({2'b00, 3'd2, 1'b0, 2'b01}, 16, 0, "R7");
    frame({2'b00, 3'd4, 1'b0, 2'b10}, 16, 0, "R12");  // R12 full off -> auto
    frame({2'b00, 3'd6, 1'b0, 2'b10}, 16, 700, "R9"); // R9 long wake gap
    frame({2'b00, 3'd1, 1'b0, 2'b10}, 16, 0, "R10");  // R10 sample too early
    frame({2'b00, 3'd7, 1'b0, 2'b11}, 16, 0, "R7");   // R7 mode 11 acts as full off
    frame({2'b00, 3'd0, 1'b0, 2'b00}, 16, 0, "R8");
    frame({2'b00, 3'd3, 1'b0, 2'b01}, 5, 0, "R11");   // R11 short abort
    frame({2'b00, 3'd6, 1'b0, 2'b01}, 10, 0, "R11");  // R11 abort after control word
    frame({2'b00, 3'd1, 1'b0, 2'b00}, 16, 0, "R11");
    frame({2'b00, 3'd2, 1'b0, 2'b00}, 16, 0, "R6");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule